// File: doc/BRIEF.md
# DDR Burst-of-Four SRAM Port

This block models a common-I/O, double-data-rate SRAM port. Each access moves four data beats over a single shared bidirectional bus. The port has one internal clock running at twice the rate of the modelled input clock, and a phase bit splits each modelled input-clock period (a "K cycle") into a rising half and a falling half. Every edge of the internal clock is one beat slot. The command inputs are sampled only on rising-half edges. The command inputs are a low-active load strobe, a read/write select and an address.

The block presets a two-bit linear counter from the low address bits, or forces those bits to zero in narrow mode. Write data is captured under per-nibble enables. Read data is driven back from an output register, and the bus is released whenever no read beat is due. A burst occupies the bus for two K cycles, so commands are taken at most every other K cycle.

The writer must leave one deselected K cycle between a read and a following write, so that the write's first beat does not meet the read's last beat on the bus.

Top module: `qburst_sram_port`

## Requirements
- R1: Every accepted command transfers exactly four beats, one per internal clock edge, so two beats fall in each K cycle.
- R2: With `lsb_zero` low, `addr[1:0]` is the starting beat index. Beat k uses index (start + k) mod 4, which wraps from 3 to 0 whatever the start. The upper address bits stay fixed.
- R3: With `lsb_zero` high, `addr[1:0]` is ignored and the beat indices run 0, 1, 2, 3.
- R4: When `ld_n` is high at a rising-half edge, that K cycle is a deselect. The bus stays high-impedance and the memory is unchanged, whatever `rw`, `addr`, `nib_we_n` and `dq` carry.
- R5: A write command (`ld_n`=0, `rw`=0) at K cycle n samples beats 0 and 1 at the two edges of cycle n+1, and beats 2 and 3 at the two edges of cycle n+2.
- R6: A read command (`ld_n`=0, `rw`=1) at K cycle n drives the beats at fixed points. Beat 0 is driven from the falling-half edge of cycle n+1. Beats 1 and 2 are driven from the two edges of cycle n+2. Beat 3 is driven from the rising-half edge of cycle n+3. The bus is high-impedance before and after these beats.
- R7: `nib_we_n[i]` is active low and guards `dq[4i+3:4i]` for the beat sampled with it. Bit 0 guards bits 3:0 and bit 1 guards bits 7:4. A nibble whose enable is high keeps its stored value.
- R8: With `c_tied` high, the output register updates on every internal edge and `c_tick` has no effect. With `c_tied` low, the output register updates only on edges where `c_tick` is high, and otherwise holds, including its bus-release state.
- R9: A command presented at the rising-half edge that directly follows an accepted command is ignored.
- R10: A read accepted two K cycles after a write to the same address returns the newly written data.
- R11: During reset the bus is high-impedance. The first internal edge after reset is released is a rising-half edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the modelled input-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Load strobe, active low, sampled on rising-half edges |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address; the low two bits are the starting beat index |
| nib_we_n | input | DATA_W/4 | Active-low nibble write enables, sampled with each write beat |
| lsb_zero | input | 1 | Narrow mode: forces the starting beat index to 0 |
| c_tied | input | 1 | Output clocks tied high: output register follows the internal clock |
| c_tick | input | 1 | Output clock edge marker, used when `c_tied` is low |
| dq | inout | DATA_W | Shared data bus |

## Verification
All stimulus is set half a clock before the edge that takes it, and every sample is taken half a clock after the edge that changes the bus. The bench counts internal edges from the command edge E0. Write beats are driven just before E2, E3, E4 and E5. Read beats are sampled just after E3, E4, E5 and E6, and the bus is checked for release just after E2 and after E7. When a read is issued two K cycles after a write, its beats are due after E7 to E10, and the bus is checked for release after E6 and after E11.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
   localparam int BEAT_N = 4;
   localparam int NIB_W  = 4;

   typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;

   // wrapping linear beat index
   function automatic logic [1:0] beat_lsb(input logic [1:0] start, input logic [1:0] k);
      return start + k;
   endfunction
endpackage

// File: rtl/qbs_cmd_gate.sv
module qbs_cmd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_n,
   output logic accept
);
   logic fall_half;   // 0: next edge is a rising-half edge
   logic skip;        // previous rising-half edge accepted a command

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_half <= 1'b0;
         skip      <= 1'b0;
      end else begin
         fall_half <= ~fall_half;
         if (!fall_half) skip <= !skip && !ld_n;
      end
   end

   assign accept = !fall_half && !skip && !ld_n;

   AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ##2 !accept);  // R9
endmodule

// File: rtl/qbs_beat_pipe.sv
module qbs_beat_pipe
   import qbs_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rw,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lsb_zero,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int WR_LAG = 1;           // write beat k at age WR_LAG+k
   localparam int RD_LAG = 2;           // read beat k at age RD_LAG+k
   localparam int DEPTH  = RD_LAG + BEAT_N;

   logic [DEPTH-1:0]  pv;
   op_e               pop [DEPTH];
   logic [ADDR_W-1:0] pad [DEPTH];
   logic [ADDR_W-1:0] base;
   logic [BEAT_N-1:0] wr_hit, rd_hit;

   assign base = lsb_zero ? {addr[ADDR_W-1:2], 2'b00} : addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            pop[i] <= OP_WR;
            pad[i] <= '0;
         end
      end else begin
         pv     <= {pv[DEPTH-2:0], accept};
         pop[0] <= op_e'(rw);
         pad[0] <= base;
         for (int i = 1; i < DEPTH; i++) begin
            pop[i] <= pop[i-1];
            pad[i] <= pad[i-1];
         end
      end
   end

   for (genvar k = 0; k < BEAT_N; k++) begin : g_slot
      assign wr_hit[k] = pv[WR_LAG+k] && (pop[WR_LAG+k] == OP_WR);
      assign rd_hit[k] = pv[RD_LAG+k] && (pop[RD_LAG+k] == OP_RD);
   end

   always_comb begin
      wr_addr = '0;
      rd_addr = '0;
      for (int k = 0; k < BEAT_N; k++) begin
         if (wr_hit[k])
            wr_addr = {pad[WR_LAG+k][ADDR_W-1:2], beat_lsb(pad[WR_LAG+k][1:0], 2'(k))};
         if (rd_hit[k])
            rd_addr = {pad[RD_LAG+k][ADDR_W-1:2], beat_lsb(pad[RD_LAG+k][1:0], 2'(k))};
      end
   end

   assign wr_en = |wr_hit;
   assign rd_en = |rd_hit;

   AST_WR_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit));  // R1
   AST_RD_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_hit));  // R1
   AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rw) |-> ##2 wr_en);  // R5
endmodule

// File: rtl/qbs_store.sv
module qbs_store
   import qbs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [DATA_W/NIB_W-1:0] keep_n,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [DATA_W-1:0]       rd_data
);
   localparam int WORDS = 1 << ADDR_W;
   localparam int NIB_N = DATA_W / NIB_W;

   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] merged;

   for (genvar i = 0; i < NIB_N; i++) begin : g_lane
      assign merged[i*NIB_W +: NIB_W] = keep_n[i] ? mem[wr_addr][i*NIB_W +: NIB_W]
                                                  : wr_data[i*NIB_W +: NIB_W];
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= merged;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/qbs_out_reg.sv
module qbs_out_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rd_data,
   output logic              oe,
   output logic [DATA_W-1:0] oq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe <= 1'b0;
         oq <= '0;
      end else if (load_en) begin
         oe <= rd_en;
         oq <= rd_data;
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(oe));  // R8
endmodule

// File: rtl/qburst_sram_port.sv
module qburst_sram_port
   import qbs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_n,
   input  logic                    rw,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W/NIB_W-1:0] nib_we_n,
   input  logic                    lsb_zero,
   input  logic                    c_tied,
   input  logic                    c_tick,
   inout  wire  [DATA_W-1:0]       dq
);
   if (DATA_W % NIB_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of the nibble width");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must leave bits above the two beat bits");
   end

   logic              acc;
   logic              wr_en, rd_en, oe;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] rdata, oq;

   qbs_cmd_gate u_gate (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .accept(acc)
   );

   qbs_beat_pipe #(.ADDR_W(ADDR_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .accept(acc), .rw(rw), .addr(addr),
      .lsb_zero(lsb_zero), .wr_en(wr_en), .wr_addr(wr_addr),
      .rd_en(rd_en), .rd_addr(rd_addr)
   );

   qbs_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(dq),
      .keep_n(nib_we_n), .rd_addr(rd_addr), .rd_data(rdata)
   );

   qbs_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .load_en(c_tied || c_tick), .rd_en(rd_en),
      .rd_data(rdata), .oe(oe), .oq(oq)
   );

   assign dq = oe ? oq : {DATA_W{1'bz}};

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && rw && c_tied) |-> ##4 (oe || !c_tied));  // R6
   AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_en);  // R4
endmodule

// File: tb/qburst_sram_port_tb.sv
module qburst_sram_port_tb;
   logic       clk = 1'b0;
   logic       rst_n, ld_n, rw, lsb_zero, c_tied, c_tick, tb_drv;
   logic [5:0] addr;
   logic [1:0] nib_we_n;
   logic [7:0] tb_dq;
   wire  [7:0] dq;
   int         n_run = 0, n_fail = 0;
   bit         done = 0;
   logic [7:0] ref_mem [64];

   always #4 clk = ~clk;   // 125 MHz
   assign dq = tb_drv ? tb_dq : 8'bz;

   qburst_sram_port u_dut (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
      .nib_we_n(nib_we_n), .lsb_zero(lsb_zero), .c_tied(c_tied),
      .c_tick(c_tick), .dq(dq)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] ba(input logic [5:0] a, input int k, input logic nz);
      logic [1:0] s;
      s = nz ? 2'b00 : a[1:0];
      return {a[5:2], 2'(s + 2'(k))};
   endfunction

   // write command at E0; beats driven before E2..E5; optional ignored command at E2
   task automatic do_wr(input logic [5:0] a, input logic [31:0] d, input logic [7:0] m,
                        input bit ghost, input logic [5:0] ga);
      ld_n = 0; rw = 0; addr = a;
      step();
      ld_n = !ghost; addr = ga;
      step();
      for (int k = 0; k < 4; k++) begin
         tb_drv = 1; tb_dq = d[8*k +: 8]; nib_we_n = m[2*k +: 2];
         if (!m[2*k])   ref_mem[ba(a, k, lsb_zero)][3:0] = d[8*k +: 4];
         if (!m[2*k+1]) ref_mem[ba(a, k, lsb_zero)][7:4] = d[8*k+4 +: 4];
         step();
         ld_n = 1;
      end
      tb_drv = 0; nib_we_n = 2'b11;
   endtask

   // read command at E0; beats due after E3..E6
   task automatic do_rd(input logic [5:0] a, input string req, input bit quiet);
      ld_n = 0; rw = 1; addr = a;
      step();
      ld_n = 1;
      step();
      step();
      chk({req, " R6 bus free before beat 0"}, dq, 8'bz);
      for (int k = 0; k < 4; k++) begin
         step();
         chk({req, " R1 beat"}, dq, quiet ? 8'bz : ref_mem[ba(a, k, lsb_zero)]);
      end
      step();
      chk({req, " R6 bus free after beat 3"}, dq, 8'bz);
   endtask

   task automatic t_reset();
      rst_n = 0; ld_n = 1; rw = 0; addr = 0; nib_we_n = 2'b11; lsb_zero = 0;
      c_tied = 1; c_tick = 0; tb_drv = 0; tb_dq = 0;
      repeat (3) step();
      chk("R11 bus idle in reset", dq, 8'bz);
      rst_n = 1;
   endtask

   task automatic t_wrap();
      // first command straight after reset: proves rising-half alignment (R11)
      do_wr(6'h09, 32'hD4C3B2A1, 8'h00, 0, 6'h00);
      do_rd(6'h08, "R2 start0 R11", 0);
      do_rd(6'h0B, "R2 start3 wrap", 0);
      do_wr(6'h0E, 32'h88776655, 8'h00, 0, 6'h00);
      do_rd(6'h0D, "R2 R5 start1", 0);
   endtask

   task automatic t_nibble();
      do_wr(6'h20, 32'h44332211, 8'h00, 0, 6'h00);
      do_wr(6'h20, 32'hDDCCBBAA, 8'b00_11_01_10, 0, 6'h00);
      do_rd(6'h20, "R7 nibble enables", 0);
   endtask

   task automatic t_narrow();
      lsb_zero = 1;
      do_wr(6'h13, 32'h5A4B3C2D, 8'h00, 0, 6'h00);
      do_rd(6'h12, "R3 narrow order", 0);
      lsb_zero = 0;
      do_rd(6'h10, "R3 narrow placement", 0);
   endtask

   task automatic t_deselect();
      ld_n = 1;
      for (int i = 0; i < 4; i++) begin
         rw = i[0]; addr = 6'(i * 7);
         step();
         chk("R4 deselect bus idle", dq, 8'bz);
      end
      for (int i = 0; i < 4; i++) begin
         tb_drv = 1; tb_dq = 8'hE0 + 8'(i); nib_we_n = 2'b00; rw = 0; addr = 6'h08;
         step();
      end
      tb_drv = 0; nib_we_n = 2'b11;
      do_rd(6'h08, "R4 memory untouched", 0);
   endtask

   task automatic t_busy();
      do_wr(6'h28, 32'h0F1E2D3C, 8'h00, 0, 6'h00);
      do_wr(6'h30, 32'h96A5B4C3, 8'h00, 1, 6'h28);
      do_rd(6'h28, "R9 ignored command", 0);
      do_rd(6'h30, "R9 first command", 0);
   endtask

   task automatic t_coherent();
      logic [31:0] d = 32'h71625344;
      ld_n = 0; rw = 0; addr = 6'h05;
      step();
      ld_n = 1;
      step();
      for (int k = 0; k < 4; k++) begin
         tb_drv = 1; tb_dq = d[8*k +: 8]; nib_we_n = 2'b00;
         ref_mem[ba(6'h05, k, 0)] = d[8*k +: 8];
         if (k == 2) begin ld_n = 0; rw = 1; addr = 6'h05; end
         if (k == 3) ld_n = 1;
         step();
      end
      tb_drv = 0; nib_we_n = 2'b11;
      step();
      chk("R10 bus free before beat 0", dq, 8'bz);
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R10 read after write", dq, ref_mem[ba(6'h05, k, 0)]);
      end
      step();
      chk("R10 bus free after beat 3", dq, 8'bz);
   endtask

   task automatic t_outclk();
      c_tied = 0; c_tick = 0;
      do_rd(6'h20, "R8 held without output clock", 1);
      c_tick = 1;
      do_rd(6'h20, "R8 output clock ticking", 0);
      c_tied = 1; c_tick = 0;
      do_rd(6'h20, "R8 tied uses input clock", 0);
   endtask

   initial begin
      t_reset();
      t_wrap();
      t_nibble();
      t_narrow();
      t_deselect();
      t_busy();
      t_coherent();
      t_outclk();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule